// File: doc/BRIEF.md
# Speed-Adaptive RGMII Receive Path

This block turns the receive side of a reduced-pin gigabit media interface into a byte stream with a valid flag and an error flag. It takes a 4-bit data bus, a single control line and the receive clock from the PHY. At gigabit speed it samples both clock edges and produces one byte per clock. At 100 and 10 Mb/s the PHY sends one nibble per clock on the rising edge, and the block joins pairs of nibbles into bytes.

Between frames the PHY places its link status on the data lines: link up or down, speed and duplex. The block decodes that status and exports it. It picks its capture mode from that status, or from a forced speed input, so that slow-rate data is never read as double-rate. Read as double-rate, it would show up as repeated nibbles with the two halves of each byte swapped. A change of capture mode is only applied while no frame is in progress.

Top module: `rgmii_rx_adapt`

## Requirements
- R1: While reset is asserted and right after it is released, rx_valid, rx_error, link_up and link_full_duplex are 0 and link_speed is 00.
- R2: In gigabit capture, every clock whose rising-edge control sample is 1 gives one byte. The rising-edge nibble is bits 3:0 and the falling-edge nibble is bits 7:4. Bytes come out in order, one per clock.
- R3: In 100 and 10 Mb/s capture, the rising-edge nibbles of a frame are taken in pairs. The first nibble of a pair is bits 3:0 and the second is bits 7:4. At most one byte is produced every two clocks, so no nibble is repeated or swapped.
- R4: Nibble pairing restarts at the start of every frame. A trailing odd nibble is dropped, and the first nibble of the next frame is again bits 3:0.
- R5: The error flag is the XOR of the rising-edge and falling-edge control samples, and it is reported together with the byte. At single rate, a byte is flagged if either of its nibbles was flagged. rx_error is only ever 1 together with rx_valid.
- R6: When both control samples are 0, the rising-edge nibble is decoded as status. Bit 0 is link up, bits 2:1 are the speed (00 = 10 Mb/s, 01 = 100 Mb/s, 10 = 1000 Mb/s) and bit 3 is full duplex. The result appears on link_up, link_speed and link_full_duplex.
- R7: Data-line values seen while either control sample is 1 leave the exported status unchanged. This includes idle with the error indication set.
- R8: With auto_speed = 1, the capture mode follows the decoded link speed.
- R9: With auto_speed = 0, the capture mode follows forced_speed (same encoding as R6), and the in-band speed has no effect on it.
- R10: A change of the selected speed takes effect only while no frame is in progress. A frame already running keeps the capture mode it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rgmii_rx_clk | input | 1 | Receive clock from the PHY |
| rst_n | input | 1 | Asynchronous active-low reset |
| rgmii_rxd | input | 4 | Receive data nibble, double or single rate |
| rgmii_rxctl | input | 1 | Receive control: data-valid on the rising edge, valid XOR error on the falling edge |
| auto_speed | input | 1 | 1 = capture mode from in-band status, 0 = from forced_speed |
| forced_speed | input | 2 | Fixed speed code used when auto_speed is 0 |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | rx_data holds a new byte this clock |
| rx_error | output | 1 | The byte on rx_data was received with an error |
| link_up | output | 1 | Decoded in-band link state |
| link_speed | output | 2 | Decoded in-band speed code |
| link_full_duplex | output | 1 | Decoded in-band duplex |

## Verification
The hardest case to reach is a change of the speed selection in the middle of a frame. The stimulus starts a gigabit frame under a forced speed, switches forced_speed to 100 Mb/s after a few bytes, and then finishes the frame. Every byte must still come out as a double-rate byte, and the next frame must be joined nibble by nibble. A frame with an odd number of nibbles, followed at once by another frame, shows whether pairing really restarts. Idle periods with the error indication set and a misleading nibble on the data lines confirm that the status is left alone.

// File: rtl/rgmii_rx_pkg.sv
package rgmii_rx_pkg;
    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;
    localparam int SPD_W  = 2;

    typedef enum logic [SPD_W-1:0] {
        SPD_10   = 2'b00,
        SPD_100  = 2'b01,
        SPD_1000 = 2'b10,
        SPD_RSVD = 2'b11
    } speed_e;

    // One receive clock worth of captured line state
    typedef struct packed {
        logic             dv;
        logic             er;
        logic [NIB_W-1:0] lo;
        logic [NIB_W-1:0] hi;
    } pair_t;
endpackage

// File: rtl/rgmii_rx_ddr_capture.sv
module rgmii_rx_ddr_capture
    import rgmii_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIB_W-1:0] rxd,
    input  logic             rxctl,
    output pair_t            pair_q
);
    logic [NIB_W-1:0] rise_dat_q, fall_dat_q;
    logic             rise_ctl_q, fall_ctl_q;
    pair_t            pair_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_dat_q <= '0;
            rise_ctl_q <= 1'b0;
        end else begin
            rise_dat_q <= rxd;
            rise_ctl_q <= rxctl;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_dat_q <= '0;
            fall_ctl_q <= 1'b0;
        end else begin
            fall_dat_q <= rxd;
            fall_ctl_q <= rxctl;
        end
    end

    // Re-time both edge samples of one clock into a single rising-edge word
    always_comb begin
        pair_d.dv = rise_ctl_q;
        pair_d.er = rise_ctl_q ^ fall_ctl_q;
        pair_d.lo = rise_dat_q;
        pair_d.hi = fall_dat_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pair_q <= '0;
        else        pair_q <= pair_d;
    end
endmodule

// File: rtl/rgmii_rx_inband_status.sv
module rgmii_rx_inband_status
    import rgmii_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  pair_t            pair,
    output logic             link_up,
    output logic [SPD_W-1:0] link_speed,
    output logic             link_fdx
);
    typedef struct packed {
        logic             up;
        logic [SPD_W-1:0] spd;
        logic             fdx;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pair.dv && !pair.er) begin
            st_d.up  = pair.lo[0];
            st_d.spd = pair.lo[2:1];
            st_d.fdx = pair.lo[3];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign link_up    = st_q.up;
    assign link_speed = st_q.spd;
    assign link_fdx   = st_q.fdx;
endmodule

// File: rtl/rgmii_rx_byte_pack.sv
module rgmii_rx_byte_pack
    import rgmii_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  pair_t             pair,
    input  logic              gig,
    output logic [BYTE_W-1:0] data,
    output logic              valid,
    output logic              err
);
    typedef struct packed {
        logic              half;
        logic [NIB_W-1:0]  hold;
        logic              hold_er;
        logic [BYTE_W-1:0] data;
        logic              vld;
        logic              err;
    } pk_t;

    pk_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        s_d.err = 1'b0;
        if (gig) begin
            s_d.half = 1'b0;
            if (pair.dv) begin
                s_d.vld  = 1'b1;
                s_d.data = {pair.hi, pair.lo};
                s_d.err  = pair.er;
            end
        end else if (!pair.dv) begin
            s_d.half = 1'b0;               // idle: next frame starts on a low nibble
        end else if (!s_q.half) begin
            s_d.half    = 1'b1;
            s_d.hold    = pair.lo;
            s_d.hold_er = pair.er;
        end else begin
            s_d.half = 1'b0;
            s_d.vld  = 1'b1;
            s_d.data = {pair.lo, s_q.hold};
            s_d.err  = pair.er | s_q.hold_er;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign data  = s_q.data;
    assign valid = s_q.vld;
    assign err   = s_q.err;
endmodule

// File: rtl/rgmii_rx_adapt.sv
module rgmii_rx_adapt
    import rgmii_rx_pkg::*;
(
    input  logic              rgmii_rx_clk,
    input  logic              rst_n,
    input  logic [NIB_W-1:0]  rgmii_rxd,
    input  logic              rgmii_rxctl,
    input  logic              auto_speed,
    input  logic [SPD_W-1:0]  forced_speed,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_error,
    output logic              link_up,
    output logic [SPD_W-1:0]  link_speed,
    output logic              link_full_duplex
);
    pair_t  pair_w;
    speed_e act_d, act_q, target;

    rgmii_rx_ddr_capture u_cap (
        .clk    (rgmii_rx_clk),
        .rst_n  (rst_n),
        .rxd    (rgmii_rxd),
        .rxctl  (rgmii_rxctl),
        .pair_q (pair_w)
    );

    rgmii_rx_inband_status u_stat (
        .clk        (rgmii_rx_clk),
        .rst_n      (rst_n),
        .pair       (pair_w),
        .link_up    (link_up),
        .link_speed (link_speed),
        .link_fdx   (link_full_duplex)
    );

    // Mode selection: applied only on clocks with no frame data
    always_comb begin
        target = auto_speed ? speed_e'(link_speed) : speed_e'(forced_speed);
        act_d  = act_q;
        if (!pair_w.dv) act_d = target;
    end

    always_ff @(posedge rgmii_rx_clk or negedge rst_n) begin
        if (!rst_n) act_q <= SPD_1000;
        else        act_q <= act_d;
    end

    rgmii_rx_byte_pack u_pack (
        .clk   (rgmii_rx_clk),
        .rst_n (rst_n),
        .pair  (pair_w),
        .gig   (act_q == SPD_1000),
        .data  (rx_data),
        .valid (rx_valid),
        .err   (rx_error)
    );
endmodule

// File: rtl/rgmii_rx_adapt_chk.sv
module rgmii_rx_adapt_chk
    import rgmii_rx_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input pair_t            pair,
    input logic [SPD_W-1:0] act_speed,
    input logic             rx_valid,
    input logic             rx_error,
    input logic             link_up,
    input logic [SPD_W-1:0] link_speed,
    input logic             link_full_duplex
);
    p_err_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_error |-> rx_valid);

    p_mode_held_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pair.dv |=> $stable(act_speed));

    p_status_idle_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pair.dv || pair.er) |=> $stable({link_up, link_speed, link_full_duplex}));

    p_single_rate_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && act_speed != SPD_1000) |=> !rx_valid);

    p_gig_byte_per_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pair.dv && act_speed == SPD_1000) |=> rx_valid);
endmodule

bind rgmii_rx_adapt rgmii_rx_adapt_chk u_chk (
    .clk              (rgmii_rx_clk),
    .rst_n            (rst_n),
    .pair             (pair_w),
    .act_speed        (act_q),
    .rx_valid         (rx_valid),
    .rx_error         (rx_error),
    .link_up          (link_up),
    .link_speed       (link_speed),
    .link_full_duplex (link_full_duplex)
);

// File: tb/tb_rgmii_rx_adapt.sv
module tb_rgmii_rx_adapt;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] rxd = '0;
    logic       ctl = 1'b0;
    logic       auto_speed = 1'b1;
    logic [1:0] forced_speed = 2'b10;
    logic [7:0] rx_data;
    logic       rx_valid, rx_error, link_up, link_full_duplex;
    logic [1:0] link_speed;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [8:0] exp_q[$];

    always #2 clk = ~clk;

    rgmii_rx_adapt dut (
        .rgmii_rx_clk(clk), .rst_n(rst_n), .rgmii_rxd(rxd), .rgmii_rxctl(ctl),
        .auto_speed(auto_speed), .forced_speed(forced_speed),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_error(rx_error),
        .link_up(link_up), .link_speed(link_speed), .link_full_duplex(link_full_duplex)
    );

    // One receive clock: rising-edge and falling-edge values
    task automatic cyc(input logic [3:0] r, input logic [3:0] f, input logic cr, input logic cf);
        @(negedge clk); #1; rxd = r; ctl = cr;
        @(posedge clk); #1; rxd = f; ctl = cf;
    endtask

    task automatic idle(input int n, input logic [3:0] st, input logic ext_err);
        for (int i = 0; i < n; i++) cyc(st, st, 1'b0, ext_err);
    endtask

    task automatic gig_byte(input logic [7:0] b, input logic e);
        cyc(b[3:0], b[7:4], 1'b1, ~e);
        exp_q.push_back({e, b});
    endtask

    task automatic sdr_nib(input logic [3:0] n, input logic e);
        cyc(n, n, 1'b1, ~e);
    endtask

    task automatic sdr_byte(input logic [7:0] b, input logic el, input logic eh);
        sdr_nib(b[3:0], el);
        sdr_nib(b[7:4], eh);
        exp_q.push_back({el | eh, b});
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops expected bytes as the design emits them
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2/R3 actual=%h err=%b expected=none (unexpected byte)", rx_data, rx_error);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                if ({rx_error, rx_data} !== e) begin
                    errors++;
                    $display("FAIL R2/R3/R5 actual=%b_%h expected=%b_%h", rx_error, rx_data, e[8], e[7:0]);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 valid", {7'b0, rx_valid}, 8'h00);
        chk("R1 link", {4'b0, link_full_duplex, link_speed, link_up}, 8'h00);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {5'b0, rx_error, rx_valid, link_up}, 8'h00);

        // R6: status 1101 -> link up, 1000, full duplex; R8 auto gigabit
        idle(6, 4'b1101, 1'b0);
        chk("R6 link_up", {7'b0, link_up}, 8'h01);
        chk("R6 speed", {6'b0, link_speed}, 8'h02);
        chk("R6 duplex", {7'b0, link_full_duplex}, 8'h01);
        // R2, R5: gigabit frame with one errored byte
        gig_byte(8'h55, 0); gig_byte(8'hD5, 0); gig_byte(8'hA3, 0);
        gig_byte(8'h0F, 1); gig_byte(8'h7C, 0); gig_byte(8'hE1, 0);
        idle(6, 4'b1011, 1'b0);
        chk("R6 speed 100", {6'b0, link_speed}, 8'h01);

        // R3, R5, R8: 100 Mb/s frame, error on a high nibble
        sdr_byte(8'h55, 0, 0); sdr_byte(8'hD5, 0, 0); sdr_byte(8'h3C, 0, 1);
        sdr_byte(8'h96, 0, 0); sdr_byte(8'hF0, 1, 0);

        // R7: idle with error indication and misleading nibble
        idle(6, 4'b0001, 1'b1);
        chk("R7 speed kept", {6'b0, link_speed}, 8'h01);
        chk("R7 duplex kept", {7'b0, link_full_duplex}, 8'h01);
        idle(2, 4'b1011, 1'b0);

        // R4: odd nibble frame, the trailing nibble is dropped
        sdr_byte(8'h21, 0, 0); sdr_byte(8'h43, 0, 0); sdr_nib(4'h9, 0);
        idle(1, 4'b1011, 1'b0);
        sdr_byte(8'hBA, 0, 0); sdr_byte(8'hDC, 0, 0);
        idle(6, 4'b0001, 1'b0);
        chk("R6 speed 10", {6'b0, link_speed}, 8'h00);
        chk("R6 half duplex", {7'b0, link_full_duplex}, 8'h00);
        // R8: 10 Mb/s uses single-rate joining
        sdr_byte(8'h5A, 0, 0); sdr_byte(8'hC3, 0, 0);
        idle(6, 4'b0011, 1'b0);

        // R9: forced gigabit while in-band says 100
        auto_speed = 1'b0; forced_speed = 2'b10;
        idle(4, 4'b0011, 1'b0);
        gig_byte(8'h12, 0); gig_byte(8'h34, 0); gig_byte(8'h56, 1);
        idle(4, 4'b0011, 1'b0);

        // R10: forced speed changed in the middle of a gigabit frame
        gig_byte(8'h9A, 0); gig_byte(8'hBC, 0);
        forced_speed = 2'b01;
        gig_byte(8'hDE, 0); gig_byte(8'hF1, 0); gig_byte(8'h23, 0);
        idle(4, 4'b0101, 1'b0);
        // R10/R9: next frame uses the new forced 100 Mb/s setting
        sdr_byte(8'h47, 0, 0); sdr_byte(8'h8E, 0, 0);
        idle(6, 4'b0101, 1'b0);
        chk("R9 status still decoded", {6'b0, link_speed}, 8'h02);

        chk("R2/R3 all bytes seen", 8'(exp_q.size()), 8'h00);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule